// File: doc/BRIEF.md
# Self-Timed SRAM Access Sequencer

This block is a synchronous controller that steps the peripheral strobes of a static memory through one access at a time. It has no request strobe: a new operation begins when the address bus holds a value different from the one it held in the previous cycle. An optional start pulse can launch an access to the same address again. Each access charges and balances the complementary bit lines, turns both off, raises one word line and one column select, and then either fires the sense amplifier and captures the read word, or pulls one line of each selected pair low to store the write word.

The address is split into a high row field, which drives a one-hot word-line decoder, and a low column field, which drives a one-hot column selector. A behavioural cell array sits behind the strobes. It is written from the pull-low drives and read into a register on the cycle the sense enable drops. Every phase length is a parameter. If the address moves while an access is in flight, the access is abandoned when its current phase ends, and the controller starts again from precharge with the new address.

Top module: `sram_seq_ctrl`

## Requirements
- R1: During and after reset, with no access started, `pc_n_o` and `eq_n_o` are low, and `wl_o`, `col_sel_o`, `sense_en_o`, `bit_pull_o`, `bitb_pull_o` and `ready_o` are all zero.
- R2: An access begins in the cycle in which `addr_i` differs from its value in the previous cycle, or in which `start_i` is high. A stable address with `start_i` low produces no `ready_o` and no word line.
- R3: `pc_n_o` always equals `eq_n_o`. While any word line is high, both are high. Every word line rises only after a cycle in which precharge was already off and all word lines were low.
- R4: The row field is `addr_i[ROW_W+COL_W-1:COL_W]` and the column field is `addr_i[COL_W-1:0]`. While an access has its word line up, `wl_o` has only bit row set and `col_sel_o` has only bit col set. Outside that phase both are zero.
- R5: On a read, `sense_en_o` rises exactly SENSE_DLY cycles after the word line rises and stays high for SENSE_CYC cycles. `rdata_o` then holds the word last stored at that address. `ready_o` is first seen PRE_CYC+1+SENSE_DLY+SENSE_CYC clock edges after the edge that detected the start.
- R6: On a write, the word line stays up for WR_CYC cycles. In those cycles, for each data bit, `bit_pull_o` is set where the bit is 0 and `bitb_pull_o` is set where it is 1, so exactly one line of each pair is pulled. In all other cycles both are zero. `ready_o` is first seen PRE_CYC+1+WR_CYC edges after the start edge.
- R7: `ready_o` is a one-cycle pulse in which word lines, sense enable and precharge are all off. Precharge never reasserts in the cycle right after a word line or sense enable was high.
- R8: An address change during an access in flight suppresses that access's `ready_o`. An abandoned write leaves the array unchanged. The access to the new address then completes with correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ROW_W+COL_W | Access address; a change starts an access |
| wr_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | DW | Write word |
| start_i | input | 1 | Explicit start pulse for a repeated address |
| pc_n_o | output | 1 | Bit-line precharge, active low |
| eq_n_o | output | 1 | Bit-line equalize, active low |
| wl_o | output | 2**ROW_W | One-hot word-line enable |
| sense_en_o | output | 1 | Sense-amplifier enable |
| col_sel_o | output | 2**COL_W | One-hot column select |
| bit_pull_o | output | DW | Pull true bit line low (writes 0) |
| bitb_pull_o | output | DW | Pull complement bit line low (writes 1) |
| rdata_o | output | DW | Captured read word |
| ready_o | output | 1 | One-cycle end-of-access pulse |

## Verification
The bench goes after the boundaries of the strobes. A design that lets precharge touch a word line, or skips the isolation cycle, shows precharge high in the cycle before the word line with no gap. A sense enable launched one cycle early or late changes the captured word and the ready latency. The bench repeats an access to an unchanged address through the start pulse; a controller that only watches the bus would hang there. It also moves the address in the middle of a precharge and in the middle of a write. A controller that ignores the move returns stale data or an extra ready. One that commits the abandoned write corrupts a location the bench reads back later.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_PRE   = 3'd1,
      PH_ISO   = 3'd2,
      PH_WL    = 3'd3,
      PH_SENSE = 3'd4,
      PH_DROP  = 3'd5,
      PH_DONE  = 3'd6
   } phase_e;

   function automatic int unsigned max4(int unsigned a, int unsigned b,
                                        int unsigned c, int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/sram_seq_dec.sv
module sram_seq_dec #(
   parameter int IN_W = 3,
   localparam int OUT_N = 1 << IN_W
) (
   input  logic [IN_W-1:0]  sel_i,
   input  logic             en_i,
   output logic [OUT_N-1:0] line_o
);

   for (genvar g = 0; g < OUT_N; g++) begin : g_line
      assign line_o[g] = en_i && (sel_i == IN_W'(g));
   end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_seq_pkg::*;
#(
   parameter int AW        = 5,
   parameter int DW        = 8,
   parameter int PRE_CYC   = 2,
   parameter int SENSE_DLY = 2,
   parameter int SENSE_CYC = 1,
   parameter int WR_CYC    = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] addr_i,
   input  logic          wr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          start_i,
   output phase_e        phase_o,
   output logic [AW-1:0] addr_q_o,
   output logic          wr_q_o,
   output logic [DW-1:0] wdata_q_o,
   output logic          commit_o,
   output logic          capture_o
);

   localparam int MAXC  = max4(PRE_CYC, SENSE_DLY, SENSE_CYC, WR_CYC);
   localparam int CNT_W = $clog2(MAXC + 1);
   localparam logic [CNT_W-1:0] PRE_LD = CNT_W'(PRE_CYC - 1);
   localparam logic [CNT_W-1:0] DLY_LD = CNT_W'(SENSE_DLY - 1);
   localparam logic [CNT_W-1:0] SA_LD  = CNT_W'(SENSE_CYC - 1);
   localparam logic [CNT_W-1:0] WR_LD  = CNT_W'(WR_CYC - 1);

   phase_e           phase, nxt;
   logic [CNT_W-1:0] cnt;
   logic [AW-1:0]    prev_addr;
   logic             pend, chg, go, last, restart;

   assign chg  = (addr_i != prev_addr) || start_i;
   assign go   = chg || pend;
   assign last = (cnt == '0);

   always_comb begin
      nxt     = phase;
      restart = 1'b0;
      unique case (phase)
         PH_IDLE:  restart = chg;
         PH_PRE:   if (last) begin
                      if (go) restart = 1'b1;
                      else    nxt = PH_ISO;
                   end
         PH_ISO:   if (go) restart = 1'b1;
                   else    nxt = PH_WL;
         PH_WL:    if (last) begin
                      if (go)          nxt = PH_DROP;
                      else if (wr_q_o) nxt = PH_DONE;
                      else             nxt = PH_SENSE;
                   end
         PH_SENSE: if (last) nxt = go ? PH_DROP : PH_DONE;
         PH_DROP:  restart = 1'b1;
         PH_DONE:  if (go) restart = 1'b1;
                   else    nxt = PH_IDLE;
         default:  nxt = PH_IDLE;
      endcase
      if (restart) nxt = PH_PRE;
   end

   always_ff @(posedge clk) begin
      prev_addr <= addr_i;
      if (rst) begin
         phase     <= PH_IDLE;
         cnt       <= '0;
         pend      <= 1'b0;
         addr_q_o  <= '0;
         wr_q_o    <= 1'b0;
         wdata_q_o <= '0;
      end else begin
         phase <= nxt;
         if (restart) begin
            addr_q_o  <= addr_i;
            wr_q_o    <= wr_i;
            wdata_q_o <= wdata_i;
            pend      <= 1'b0;
            cnt       <= PRE_LD;
         end else begin
            pend <= pend || chg;
            if (nxt != phase) begin
               unique case (nxt)
                  PH_WL:    cnt <= wr_q_o ? WR_LD : DLY_LD;
                  PH_SENSE: cnt <= SA_LD;
                  default:  cnt <= '0;
               endcase
            end else if (!last) begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   assign phase_o   = phase;
   assign commit_o  = (phase == PH_WL) && last && !go && wr_q_o;
   assign capture_o = (phase == PH_SENSE) && last && !go;

endmodule

// File: rtl/sram_seq_cell_array.sv
module sram_seq_cell_array #(
   parameter int ROW_W = 3,
   parameter int COL_W = 2,
   parameter int DW    = 8,
   localparam int ROWS = 1 << ROW_W,
   localparam int COLS = 1 << COL_W
) (
   input  logic             clk,
   input  logic             we_i,
   input  logic [ROWS-1:0]  wl_i,
   input  logic [ROW_W-1:0] row_i,
   input  logic [COL_W-1:0] col_i,
   input  logic [DW-1:0]    bitb_pull_i,
   output logic [DW-1:0]    rdata_o
);

   logic [DW-1:0] cells [ROWS][COLS];

   // a pulled complement line leaves a 1 in the cell; a pulled true line a 0
   always_ff @(posedge clk) begin
      for (int r = 0; r < ROWS; r++) begin
         if (we_i && wl_i[r]) cells[r][col_i] <= bitb_pull_i;
      end
   end

   assign rdata_o = cells[row_i][col_i];

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
   import sram_seq_pkg::*;
#(
   parameter int ROW_W     = 3,
   parameter int COL_W     = 2,
   parameter int DW        = 8,
   parameter int PRE_CYC   = 2,
   parameter int SENSE_DLY = 2,
   parameter int SENSE_CYC = 1,
   parameter int WR_CYC    = 2,
   localparam int AW   = ROW_W + COL_W,
   localparam int ROWS = 1 << ROW_W,
   localparam int COLS = 1 << COL_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [AW-1:0]    addr_i,
   input  logic             wr_i,
   input  logic [DW-1:0]    wdata_i,
   input  logic             start_i,
   output logic             pc_n_o,
   output logic             eq_n_o,
   output logic [ROWS-1:0]  wl_o,
   output logic             sense_en_o,
   output logic [COLS-1:0]  col_sel_o,
   output logic [DW-1:0]    bit_pull_o,
   output logic [DW-1:0]    bitb_pull_o,
   output logic [DW-1:0]    rdata_o,
   output logic             ready_o
);

   if (ROW_W < 1 || ROW_W > 10) begin : g_bad_row
      $error("sram_seq_ctrl: ROW_W out of range");
   end
   if (COL_W < 1 || COL_W > 6) begin : g_bad_col
      $error("sram_seq_ctrl: COL_W out of range");
   end
   if (DW < 1) begin : g_bad_dw
      $error("sram_seq_ctrl: DW must be positive");
   end
   if (PRE_CYC < 1 || SENSE_DLY < 1 || SENSE_CYC < 1 || WR_CYC < 1) begin : g_bad_len
      $error("sram_seq_ctrl: every phase length must be at least one cycle");
   end

   phase_e        phase;
   logic [AW-1:0] addr_q;
   logic          wr_q, commit, capture, wl_on, drive;
   logic [DW-1:0] wdata_q, cell_rd;

   sram_seq_fsm #(
      .AW(AW), .DW(DW), .PRE_CYC(PRE_CYC), .SENSE_DLY(SENSE_DLY),
      .SENSE_CYC(SENSE_CYC), .WR_CYC(WR_CYC)
   ) u_fsm (
      .clk(clk), .rst(rst), .addr_i(addr_i), .wr_i(wr_i),
      .wdata_i(wdata_i), .start_i(start_i), .phase_o(phase),
      .addr_q_o(addr_q), .wr_q_o(wr_q), .wdata_q_o(wdata_q),
      .commit_o(commit), .capture_o(capture)
   );

   assign wl_on = (phase == PH_WL) || (phase == PH_SENSE);
   assign drive = (phase == PH_WL) && wr_q;

   sram_seq_dec #(.IN_W(ROW_W)) u_row_dec (
      .sel_i(addr_q[AW-1:COL_W]), .en_i(wl_on), .line_o(wl_o)
   );

   sram_seq_dec #(.IN_W(COL_W)) u_col_dec (
      .sel_i(addr_q[COL_W-1:0]), .en_i(wl_on), .line_o(col_sel_o)
   );

   assign pc_n_o      = !((phase == PH_IDLE) || (phase == PH_PRE));
   assign eq_n_o      = pc_n_o;
   assign sense_en_o  = (phase == PH_SENSE);
   assign bit_pull_o  = drive ? ~wdata_q : '0;
   assign bitb_pull_o = drive ?  wdata_q : '0;
   assign ready_o     = (phase == PH_DONE);

   sram_seq_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW)) u_cells (
      .clk(clk), .we_i(commit), .wl_i(wl_o),
      .row_i(addr_q[AW-1:COL_W]), .col_i(addr_q[COL_W-1:0]),
      .bitb_pull_i(bitb_pull_o), .rdata_o(cell_rd)
   );

   always_ff @(posedge clk) begin
      if (rst)          rdata_o <= '0;
      else if (capture) rdata_o <= cell_rd;
   end

endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
   parameter int ROW_W     = 3,
   parameter int COL_W     = 2,
   parameter int DW        = 8,
   parameter int SENSE_DLY = 2,
   localparam int ROWS  = 1 << ROW_W,
   localparam int COLS  = 1 << COL_W,
   localparam int AGE_W = $clog2(SENSE_DLY + 2) + 1
) (
   input logic            clk,
   input logic            rst,
   input logic            pc_n_o,
   input logic            eq_n_o,
   input logic [ROWS-1:0] wl_o,
   input logic            sense_en_o,
   input logic [COLS-1:0] col_sel_o,
   input logic [DW-1:0]   bit_pull_o,
   input logic [DW-1:0]   bitb_pull_o,
   input logic            ready_o
);

   logic             wl_any;
   logic [AGE_W-1:0] wl_age;

   assign wl_any = |wl_o;

   always_ff @(posedge clk) begin
      if (rst || !wl_any)          wl_age <= '0;
      else if (wl_age != '1)       wl_age <= wl_age + 1'b1;
   end

   // R3
   pc_eq_pair_chk: assert property (@(posedge clk) disable iff (rst)
      pc_n_o == eq_n_o);
   // R3
   wl_pc_excl_chk: assert property (@(posedge clk) disable iff (rst)
      wl_any |-> pc_n_o);
   // R3
   wl_after_iso_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(wl_any) |-> $past(pc_n_o));
   // R4
   wl_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(wl_o) && $onehot0(col_sel_o));
   // R4
   col_with_wl_chk: assert property (@(posedge clk) disable iff (rst)
      wl_any == (|col_sel_o));
   // R5
   sense_in_wl_chk: assert property (@(posedge clk) disable iff (rst)
      sense_en_o |-> wl_any);
   // R5
   sense_delay_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(sense_en_o) |-> (wl_age == AGE_W'(SENSE_DLY)));
   // R6
   pull_excl_chk: assert property (@(posedge clk) disable iff (rst)
      (bit_pull_o & bitb_pull_o) == '0);
   // R6
   pull_in_wl_chk: assert property (@(posedge clk) disable iff (rst)
      ((|bit_pull_o) || (|bitb_pull_o)) |-> (wl_any && !sense_en_o));
   // R7
   ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      ready_o |-> (!wl_any && !sense_en_o && pc_n_o));
   // R7
   ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      ready_o |=> !ready_o);
   // R7
   pc_after_off_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(pc_n_o) |-> (!$past(wl_any) && !$past(sense_en_o)));

endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
   .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .SENSE_DLY(SENSE_DLY)
) u_chk (
   .clk(clk), .rst(rst), .pc_n_o(pc_n_o), .eq_n_o(eq_n_o), .wl_o(wl_o),
   .sense_en_o(sense_en_o), .col_sel_o(col_sel_o), .bit_pull_o(bit_pull_o),
   .bitb_pull_o(bitb_pull_o), .ready_o(ready_o)
);

// File: tb/tb_sram_seq_ctrl.sv
`timescale 1ns/1ps
module tb_sram_seq_ctrl;

   localparam int ROW_W = 3, COL_W = 2, DW = 8;
   localparam int PRE_CYC = 2, SENSE_DLY = 2, SENSE_CYC = 1, WR_CYC = 2;
   localparam int AW = ROW_W + COL_W, ROWS = 1 << ROW_W, COLS = 1 << COL_W;
   localparam int N_RD = PRE_CYC + 1 + SENSE_DLY + SENSE_CYC;
   localparam int N_WR = PRE_CYC + 1 + WR_CYC;

   typedef struct { bit is_rd; logic [DW-1:0] data; int due; } exp_t;

   logic            clk = 1'b0, rst = 1'b1;
   logic [AW-1:0]   addr_i = '0;
   logic            wr_i = 1'b0, start_i = 1'b0;
   logic [DW-1:0]   wdata_i = '0;
   logic            pc_n_o, eq_n_o, sense_en_o, ready_o;
   logic [ROWS-1:0] wl_o;
   logic [COLS-1:0] col_sel_o;
   logic [DW-1:0]   bit_pull_o, bitb_pull_o, rdata_o;

   int checks = 0, fails = 0, cyc = 0;
   exp_t q[$];
   logic [DW-1:0] shadow [1<<AW];
   bit chk_en = 1'b0, cur_wr = 1'b0;
   logic [AW-1:0] cur_addr = '0;
   logic [DW-1:0] cur_data = '0;
   logic prev_wl = 1'b0, prev_pc_n = 1'b0, prev_sense = 1'b0;
   int wl_age = 0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sram_seq_ctrl #(
      .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .PRE_CYC(PRE_CYC),
      .SENSE_DLY(SENSE_DLY), .SENSE_CYC(SENSE_CYC), .WR_CYC(WR_CYC)
   ) dut (.*);

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // monitor: per-cycle strobe rules and scoreboard
   always @(negedge clk) begin
      if (!rst) begin
         chk(pc_n_o == eq_n_o, "R3", "pc/eq pair", eq_n_o, pc_n_o);
         if (|wl_o) chk(pc_n_o, "R3", "precharge with word line", pc_n_o, 1);
         if ((|wl_o) && !prev_wl) chk(prev_pc_n, "R3", "isolation before wl", prev_pc_n, 1);
         if (!pc_n_o && prev_pc_n)
            chk(!prev_wl && !prev_sense, "R7", "wl/sense before precharge", {prev_wl, prev_sense}, 0);
         if (sense_en_o && !prev_sense) chk(wl_age == SENSE_DLY, "R5", "sense delay", wl_age, SENSE_DLY);
         if (chk_en && (|wl_o)) begin
            chk(wl_o == ROWS'(1) << cur_addr[AW-1:COL_W], "R4", "word line", wl_o,
                ROWS'(1) << cur_addr[AW-1:COL_W]);
            chk(col_sel_o == COLS'(1) << cur_addr[COL_W-1:0], "R4", "column select", col_sel_o,
                COLS'(1) << cur_addr[COL_W-1:0]);
            if (cur_wr && !sense_en_o) begin
               chk(bit_pull_o == ~cur_data, "R6", "true pull", bit_pull_o, ~cur_data);
               chk(bitb_pull_o == cur_data, "R6", "complement pull", bitb_pull_o, cur_data);
            end else begin
               chk((bit_pull_o | bitb_pull_o) == '0, "R6", "pull in read", bit_pull_o | bitb_pull_o, 0);
            end
         end
         if (ready_o) begin
            chk(!(|wl_o) && !sense_en_o && pc_n_o, "R7", "ready quiet",
                {|wl_o, sense_en_o, pc_n_o}, 1);
            if (q.size() == 0) begin
               chk(0, "R8", "unexpected ready", 1, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               if (e.due >= 0) chk(cyc == e.due, e.is_rd ? "R5" : "R6", "ready latency", cyc, e.due);
               if (e.is_rd) chk(rdata_o == e.data, "R5", "read data", rdata_o, e.data);
            end
         end
         if (prev_wl && !(|wl_o) == 1'b0 && ready_o) chk(0, "R7", "ready pulse", 1, 0);
         wl_age     = (|wl_o) ? wl_age + 1 : 0;
         prev_wl    = |wl_o;
         prev_pc_n  = pc_n_o;
         prev_sense = sense_en_o;
      end
   end

   task automatic wait_done();
      while (q.size() != 0) @(negedge clk);
      @(negedge clk);
      chk(!ready_o, "R7", "ready one cycle", ready_o, 0);
   endtask

   task automatic access(logic [AW-1:0] a, bit w, logic [DW-1:0] d);
      exp_t e;
      @(negedge clk);
      start_i = (a == addr_i);
      addr_i = a; wr_i = w; wdata_i = d;
      chk_en = 1'b1; cur_addr = a; cur_wr = w; cur_data = d;
      e.is_rd = !w;
      e.data  = w ? '0 : shadow[a];
      e.due   = cyc + 1 + (w ? N_WR : N_RD);
      if (w) shadow[a] = d;
      q.push_back(e);
      @(negedge clk);
      start_i = 1'b0;
      wait_done();
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      exp_t e;
      int rdy;
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(!pc_n_o && !eq_n_o && wl_o == 0 && !sense_en_o && !ready_o && col_sel_o == 0,
          "R1", "reset strobes", {pc_n_o, eq_n_o, sense_en_o, ready_o}, 0);
      rst = 1'b0;
      // R2: stable address, no start -> nothing happens
      rdy = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (ready_o || (|wl_o)) rdy++;
      end
      chk(rdy == 0, "R2", "idle activity", rdy, 0);
      chk(!pc_n_o && (bit_pull_o | bitb_pull_o) == 0, "R1", "idle precharge", pc_n_o, 0);

      // writes: first to address 0 via start pulse (R2), then by address changes
      access(5'd0,  1, 8'h3C);
      access(5'd3,  1, 8'hA5);
      access(5'd31, 1, 8'hFF);
      access(5'd17, 1, 8'h00);
      access(5'd10, 1, 8'h5A);
      // reads back (R5)
      access(5'd10, 0, 8'h00);
      access(5'd17, 0, 8'h00);
      access(5'd31, 0, 8'h00);
      access(5'd0,  0, 8'h00);
      access(5'd3,  0, 8'h00);
      access(5'd3,  0, 8'h00);   // R2 repeat through start pulse
      access(5'd3,  1, 8'h96);   // R6 overwrite via start
      access(5'd3,  0, 8'h00);

      // R8: address move during precharge of a read
      chk_en = 1'b0;
      @(negedge clk);
      addr_i = 5'd17; wr_i = 1'b0;
      @(negedge clk);
      addr_i = 5'd31;
      e.is_rd = 1; e.data = shadow[31]; e.due = -1;
      q.push_back(e);
      wait_done();

      // R8: address move while a write drives the bit lines
      @(negedge clk);
      addr_i = 5'd10; wr_i = 1'b1; wdata_i = 8'h11;
      while (!(|bit_pull_o) && !(|bitb_pull_o)) @(negedge clk);
      addr_i = 5'd0; wr_i = 1'b0;
      e.is_rd = 1; e.data = shadow[0]; e.due = -1;
      q.push_back(e);
      wait_done();
      access(5'd10, 0, 8'h00);   // R8 abandoned write left old word

      repeat (5) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule